// File: doc/BRIEF.md
# Spread Spectrum Triangle Profile Generator

This block makes the frequency-offset word that a fractional-N feedback divider adds to its nominal ratio. Adding the word spreads the synthesized clock over a small band and so lowers its peak emission. On every reference clock the block steps a signed offset, in units of 0.001 %, along a linear triangle. The user sets the depth of the triangle with a deviation code. The user sets its duration with a count of reference cycles per modulation period. A spread-type select picks a band centred on the nominal frequency or a band lying wholly below it.

The block checks its settings before it modulates. It refuses a deviation code outside the range of the selected spread type, and it refuses a period too short for the reference. In both cases it raises a flag and keeps the offset at zero. It also stays at zero while an external status input reports that the reference is too slow to modulate. The block restarts its profile from the beginning whenever it is disabled or its settings change.

After a setting is accepted, an iterative divider works out the per-cycle increment and remainder. The triangle then starts and reaches its peak exactly at its turning point.

Top module: `ss_tri_gen`

## Requirements
- R1: With `mode_down` = 0 (center spread), the peak P is `dev_code`×125 and codes 1 to 24 are legal. The offset lies between −P and +P and reaches both extremes.
- R2: With `mode_down` = 1 (down spread), the peak P is `dev_code`×250 and codes 1 to 16 are legal. The offset lies between −P and 0 and reaches both ends.
- R3: A deviation code of 0, or one above the selected type's maximum, sets `invalid` one edge later and holds `offset` at 0.
- R4: A `period_cycles` value below 225 sets `invalid` one edge later and holds `offset` at 0. The flag depends on the deviation code and period only, not on `enable` or `ref_slow`.
- R5: While `ref_slow` is 1, `offset` is 0 after the next edge and the profile restarts once `ref_slow` clears.
- R6: Let H = 2×floor(`period_cycles`/4) and let A = 2P (center) or P (down). A phase t moves by one per cycle, rising from 0 to H and falling back to 0, so the period is 2H. The level is floor(A×t/H). The offset is level−P in center spread and −level in down spread.
- R7: A center profile starts at t = H/2, so its first value is 0, and it then rises. A down profile starts at t = 0, so its first value is 0, and it then falls.
- R8: Dropping `enable`, or changing `mode_down`, `dev_code` or `period_cycles`, returns `offset` to 0 after the edge that samples the change. The profile then restarts from its first value.
- R9: Call the edge that accepts a valid, enabled setting with `ref_slow` = 0 edge 0. The offset stays 0 through edge 12. The first profile value is shown after edge 13, and t advances on each later edge.
- R10: During and after synchronous reset, `offset` and `invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Modulation enable |
| mode_down | input | 1 | 1 = down spread, 0 = center spread |
| dev_code | input | 5 | Deviation code (peak in steps of the selected type) |
| period_cycles | input | 16 | Reference cycles per modulation period |
| ref_slow | input | 1 | Reference below the minimum frequency for modulation |
| offset | output | 16 | Signed frequency offset, units of 0.001 % |
| invalid | output | 1 | Settings out of range |

## Verification
The `invalid` flag is registered, so it reflects the settings seen at the previous edge. Zeroing after a disable, a slow-reference report or a setting change is visible right after the edge that samples it. A newly accepted setting shows its first profile value 13 edges after acceptance, and the value then moves on each edge. The bench drives inputs on the falling edge and advances its own reference model on each rising edge. It compares `offset` and `invalid` at the falling edge, so every check sees exactly the edges counted in these rules. Directed cases look at the first profile value, the step after it and the extremes reached. Random episodes cover mixed codes, periods and interruptions.

// File: rtl/ss_pkg.sv
package ss_pkg;

    localparam int DEV_W      = 5;
    localparam int PER_W      = 16;
    localparam int HALF_W     = PER_W - 1;
    localparam int AMP_W      = 13;
    localparam int OFF_W      = 16;
    localparam int CTR_STEP   = 125;
    localparam int DN_STEP    = 250;
    localparam int CTR_MAXC   = 24;
    localparam int DN_MAXC    = 16;
    localparam int MIN_PERIOD = 225;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_RUN  = 2'd2
    } ss_state_e;

    typedef struct packed {
        logic              down;
        logic [DEV_W-1:0]  dev;
        logic [PER_W-1:0]  period;
    } ss_cfg_t;

    typedef struct packed {
        logic              ok;
        logic [AMP_W-1:0]  peak;
        logic [AMP_W-1:0]  span;
        logic [HALF_W-1:0] half;
    } ss_derived_t;

    function automatic logic [DEV_W-1:0] max_code(input logic down);
        return down ? DEV_W'(DN_MAXC) : DEV_W'(CTR_MAXC);
    endfunction

    function automatic logic [AMP_W-1:0] peak_of(input logic down, input logic [DEV_W-1:0] dev);
        logic [AMP_W-1:0] step;
        step = down ? AMP_W'(DN_STEP) : AMP_W'(CTR_STEP);
        return AMP_W'(dev) * step;
    endfunction

endpackage

// File: rtl/ss_cfg_check.sv
module ss_cfg_check
    import ss_pkg::*;
#(
    parameter int MIN_P = ss_pkg::MIN_PERIOD
) (
    input  ss_cfg_t     cfg,
    output ss_derived_t drv
);
    logic dev_ok;
    logic per_ok;
    logic [AMP_W-1:0] pk;

    always_comb begin
        dev_ok   = (cfg.dev != '0) && (cfg.dev <= max_code(cfg.down));
        per_ok   = (cfg.period >= PER_W'(MIN_P));
        pk       = peak_of(cfg.down, cfg.dev);
        drv.ok   = dev_ok && per_ok;
        drv.peak = pk;
        drv.span = cfg.down ? pk : AMP_W'({pk, 1'b0});
        drv.half = {cfg.period[PER_W-1:2], 1'b0};
    end
endmodule

// File: rtl/ss_divider.sv
module ss_divider #(
    parameter int DVD_W = 13,
    parameter int DSR_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DSR_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic [DSR_W-1:0] remainder,
    output logic             done
);
    localparam int CW = (DVD_W > 1) ? $clog2(DVD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DVD_W - 1);

    logic [DVD_W-1:0] dvd_sh;
    logic [CW-1:0]    cnt;
    logic             busy;
    logic [DSR_W:0]   trial;
    logic [DSR_W:0]   diff;
    logic             ge;

    always_comb begin
        trial = {remainder, dvd_sh[DVD_W-1]};
        diff  = trial - {1'b0, divisor};
        ge    = (trial >= {1'b0, divisor});
        done  = busy && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_sh    <= '0;
            cnt       <= '0;
            busy      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else if (start) begin
            dvd_sh    <= dividend;
            cnt       <= '0;
            busy      <= 1'b1;
            quotient  <= '0;
            remainder <= '0;
        end else if (busy) begin
            remainder <= ge ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
            quotient  <= {quotient[DVD_W-2:0], ge};
            dvd_sh    <= {dvd_sh[DVD_W-2:0], 1'b0};
            cnt       <= cnt + 1'b1;
            if (cnt == LAST) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/ss_tri_core.sv
module ss_tri_core #(
    parameter int AMP_W  = 13,
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [HALF_W-1:0] start_t,
    input  logic [AMP_W-1:0]  start_level,
    input  logic [HALF_W-1:0] half,
    input  logic [AMP_W-1:0]  inc_q,
    input  logic [HALF_W-1:0] inc_r,
    output logic [AMP_W-1:0]  level
);
    logic [HALF_W-1:0] t;
    logic [HALF_W-1:0] rem;
    logic              dir_up;

    logic [HALF_W:0]   rem_up;
    logic              carry;
    logic              borrow;
    logic [HALF_W:0]   rem_dn;
    logic [HALF_W-1:0] t_nx;
    logic [AMP_W-1:0]  level_nx;
    logic [HALF_W-1:0] rem_nx;
    logic              dir_nx;

    always_comb begin
        rem_up = {1'b0, rem} + {1'b0, inc_r};
        carry  = (rem_up >= {1'b0, half});
        borrow = (rem < inc_r);
        rem_dn = borrow ? ({1'b0, rem} + {1'b0, half} - {1'b0, inc_r})
                        : ({1'b0, rem} - {1'b0, inc_r});
        if (dir_up) begin
            t_nx     = t + 1'b1;
            level_nx = level + inc_q + AMP_W'(carry);
            rem_nx   = carry ? HALF_W'(rem_up - {1'b0, half}) : rem_up[HALF_W-1:0];
            dir_nx   = (t_nx != half);
        end else begin
            t_nx     = t - 1'b1;
            level_nx = level - inc_q - AMP_W'(borrow);
            rem_nx   = rem_dn[HALF_W-1:0];
            dir_nx   = (t_nx == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t      <= '0;
            rem    <= '0;
            level  <= '0;
            dir_up <= 1'b1;
        end else if (load) begin
            t      <= start_t;
            rem    <= '0;
            level  <= start_level;
            dir_up <= 1'b1;
        end else if (step) begin
            t      <= t_nx;
            rem    <= rem_nx;
            level  <= level_nx;
            dir_up <= dir_nx;
        end
    end
endmodule

// File: rtl/ss_tri_gen.sv
module ss_tri_gen
    import ss_pkg::*;
#(
    parameter int MIN_P = ss_pkg::MIN_PERIOD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    mode_down,
    input  logic [DEV_W-1:0]        dev_code,
    input  logic [PER_W-1:0]        period_cycles,
    input  logic                    ref_slow,
    output logic signed [OFF_W-1:0] offset,
    output logic                    invalid
);
    ss_cfg_t     cfg_live;
    ss_cfg_t     cfg_snap;
    ss_cfg_t     cfg_pair [2];
    ss_derived_t drv_pair [2];
    ss_derived_t drv_live;
    ss_derived_t drv_snap;
    ss_state_e   state;

    logic              go;
    logic              changed;
    logic              hold_ok;
    logic              div_start;
    logic              div_done;
    logic [AMP_W-1:0]  inc_q;
    logic [HALF_W-1:0] inc_r;
    logic              core_load;
    logic              core_step;
    logic [HALF_W-1:0] start_t;
    logic [AMP_W-1:0]  start_level;
    logic [AMP_W-1:0]  level;
    logic signed [OFF_W-1:0] lvl_s;
    logic signed [OFF_W-1:0] peak_s;

    assign cfg_live    = '{down: mode_down, dev: dev_code, period: period_cycles};
    assign cfg_pair[0] = cfg_live;
    assign cfg_pair[1] = cfg_snap;

    for (genvar i = 0; i < 2; i++) begin : g_check
        ss_cfg_check #(.MIN_P(MIN_P)) u_check (
            .cfg (cfg_pair[i]),
            .drv (drv_pair[i])
        );
    end

    assign drv_live = drv_pair[0];
    assign drv_snap = drv_pair[1];

    always_comb begin
        go        = enable && drv_live.ok && !ref_slow;
        changed   = (cfg_live != cfg_snap);
        hold_ok   = go && !changed;
        div_start = (state == ST_IDLE) && go;
        core_load = (state == ST_DIV) && hold_ok && div_done;
        core_step = (state == ST_RUN) && hold_ok;
        start_t     = cfg_snap.down ? '0 : {1'b0, drv_snap.half[HALF_W-1:1]};
        start_level = cfg_snap.down ? '0 : drv_snap.peak;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg_snap <= '0;
            invalid  <= 1'b0;
        end else begin
            invalid <= !drv_live.ok;
            unique case (state)
                ST_IDLE: if (go) begin
                    state    <= ST_DIV;
                    cfg_snap <= cfg_live;
                end
                ST_DIV: begin
                    if (!hold_ok)      state <= ST_IDLE;
                    else if (div_done) state <= ST_RUN;
                end
                ST_RUN: if (!hold_ok) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    ss_divider #(.DVD_W(AMP_W), .DSR_W(HALF_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (div_start),
        .dividend  (drv_live.span),
        .divisor   (drv_snap.half),
        .quotient  (inc_q),
        .remainder (inc_r),
        .done      (div_done)
    );

    ss_tri_core #(.AMP_W(AMP_W), .HALF_W(HALF_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .load        (core_load),
        .step        (core_step),
        .start_t     (start_t),
        .start_level (start_level),
        .half        (drv_snap.half),
        .inc_q       (inc_q),
        .inc_r       (inc_r),
        .level       (level)
    );

    always_comb begin
        lvl_s  = signed'({{(OFF_W-AMP_W){1'b0}}, level});
        peak_s = signed'({{(OFF_W-AMP_W){1'b0}}, drv_snap.peak});
        if (state != ST_RUN)    offset = '0;
        else if (cfg_snap.down) offset = -lvl_s;
        else                    offset = lvl_s - peak_s;
    end
endmodule

// File: rtl/ss_tri_gen_chk.sv
module ss_tri_gen_chk
    import ss_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    enable,
    input logic                    mode_down,
    input logic [DEV_W-1:0]        dev_code,
    input logic [PER_W-1:0]        period_cycles,
    input logic                    ref_slow,
    input logic signed [OFF_W-1:0] offset,
    input logic                    invalid
);
    assert_disable_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (offset == 0));

    assert_code_change_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (dev_code != $past(dev_code)) |=> (offset == 0));

    assert_slow_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ref_slow |=> (offset == 0));

    assert_dev_zero_invalid_R3: assert property (@(posedge clk) disable iff (rst)
        (dev_code == 0) |=> invalid);

    assert_short_period_invalid_R4: assert property (@(posedge clk) disable iff (rst)
        (period_cycles < 16'd225) |=> (invalid && offset == 0));

    assert_down_nonpos_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_down && $past(mode_down)) |-> (offset <= 0 && offset >= -16'sd4000));

    assert_center_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (!mode_down && !$past(mode_down)) |-> (offset <= 16'sd3000 && offset >= -16'sd3000));
endmodule

bind ss_tri_gen ss_tri_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .mode_down     (mode_down),
    .dev_code      (dev_code),
    .period_cycles (period_cycles),
    .ref_slow      (ref_slow),
    .offset        (offset),
    .invalid       (invalid)
);

// File: tb/sim_ss_tri_gen.sv
module sim_ss_tri_gen;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               enable = 1'b0;
    logic               mode_down = 1'b0;
    logic [4:0]         dev_code = 5'd1;
    logic [15:0]        period_cycles = 16'd1000;
    logic               ref_slow = 1'b0;
    logic signed [15:0] offset;
    logic               invalid;

    always #10 clk = ~clk;

    ss_tri_gen u0 (
        .clk(clk), .rst(rst), .enable(enable), .mode_down(mode_down),
        .dev_code(dev_code), .period_cycles(period_cycles), .ref_slow(ref_slow),
        .offset(offset), .invalid(invalid)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    string tag = "R10";

    // reference model state
    int  m_st = 0;          // 0 idle, 1 setup, 2 run
    int  m_wc = 0;
    int  m_down, m_dev, m_per;
    int  m_t = 0;
    int  m_up = 1;
    int  m_inv = 0;
    int  m_first = 0;
    int  seen_max, seen_min;

    function automatic int b_ok(int dn, int dv, int pr);
        int mx = dn ? 16 : 24;
        return (dv >= 1 && dv <= mx && pr >= 225) ? 1 : 0;
    endfunction

    function automatic int b_peak(int dn, int dv);
        return dn ? dv * 250 : dv * 125;
    endfunction

    function automatic int b_half(int pr);
        return (pr / 4) * 2;
    endfunction

    function automatic int b_expect();
        int a, h, lvl, p;
        if (m_st != 2) return 0;
        p   = b_peak(m_down, m_dev);
        a   = m_down ? p : 2 * p;
        h   = b_half(m_per);
        lvl = (a * m_t) / h;
        return m_down ? -lvl : lvl - p;
    endfunction

    task automatic check(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic model_edge();
        int go, same;
        if (rst) begin
            m_st = 0; m_inv = 0; return;
        end
        go   = enable && b_ok(mode_down, dev_code, period_cycles) && !ref_slow;
        same = (mode_down == m_down) && (dev_code == m_dev) && (period_cycles == m_per);
        m_inv = !b_ok(mode_down, dev_code, period_cycles);
        m_first = 0;
        if (m_st == 0) begin
            if (go) begin
                m_st = 1; m_wc = 0;
                m_down = mode_down; m_dev = dev_code; m_per = period_cycles;
            end
        end else if (!go || !same) begin
            m_st = 0;
        end else if (m_st == 1) begin
            m_wc++;
            if (m_wc == 13) begin
                m_st = 2; m_up = 1; m_first = 1;
                m_t = m_down ? 0 : b_half(m_per) / 2;
            end
        end else begin
            if (m_up) begin
                m_t++; if (m_t == b_half(m_per)) m_up = 0;
            end else begin
                m_t--; if (m_t == 0) m_up = 1;
            end
        end
    endtask

    // one clock: model follows the rising edge, outputs compared at the falling edge
    task automatic tick();
        int e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        e = b_expect();
        check({tag, " offset"}, offset, e);
        check({tag, " invalid"}, int'(invalid), m_inv);
        if (m_st == 2) begin
            if (offset > seen_max) seen_max = offset;
            if (offset < seen_min) seen_min = offset;
        end
    endtask

    task automatic set_cfg(int en, int dn, int dv, int pr);
        enable = en[0]; mode_down = dn[0]; dev_code = dv[4:0]; period_cycles = pr[15:0];
        seen_max = -100000; seen_min = 100000;
    endtask

    initial begin
        int lat;
        void'($urandom(32'd7351));
        @(negedge clk);
        // R10: reset state
        repeat (3) begin
            @(negedge clk);
            check("R10 reset offset", offset, 0);
            check("R10 reset invalid", int'(invalid), 0);
        end
        rst = 1'b0;

        // R1 / R7: full center spread at the shortest legal period
        tag = "R1";
        set_cfg(1, 0, 24, 225);
        repeat (14) tick();
        check("R7 center first value", offset, 0);
        tick();
        check("R7 center rises", int'(offset > 0), 1);
        repeat (400) tick();
        check("R1 center max", seen_max, 3000);
        check("R1 center min", seen_min, -3000);

        // R8: code change mid-run
        tag = "R8";
        dev_code = 5'd5;
        tick();
        check("R8 zero after change", offset, 0);
        repeat (100) tick();
        enable = 1'b0;
        tick();
        check("R8 zero after disable", offset, 0);
        repeat (5) tick();

        // R2 / R9: full down spread, first step 13 edges after acceptance
        tag = "R9";
        set_cfg(1, 1, 16, 225);
        lat = 0;
        tick();
        while (offset == 0 && lat < 40) begin tick(); lat++; end
        check("R9 edges to first step", lat, 14);
        tag = "R2";
        seen_max = -100000; seen_min = 100000;
        repeat (300) tick();
        check("R2 down max", seen_max, 0);
        check("R2 down min", seen_min, -4000);

        // R3: illegal deviation codes
        tag = "R3";
        set_cfg(1, 0, 25, 1000); repeat (20) tick();
        check("R3 center code 25 flagged", int'(invalid), 1);
        set_cfg(1, 1, 17, 1000); repeat (20) tick();
        check("R3 down code 17 flagged", int'(invalid), 1);
        set_cfg(1, 0, 0, 1000);  repeat (20) tick();
        check("R3 code 0 offset", offset, 0);

        // R4: period boundary
        tag = "R4";
        set_cfg(1, 1, 8, 224); repeat (20) tick();
        check("R4 period 224 flagged", int'(invalid), 1);
        set_cfg(0, 1, 8, 224); repeat (3) tick();
        check("R4 flagged while disabled", int'(invalid), 1);
        tag = "R6";
        set_cfg(1, 1, 8, 227); repeat (600) tick();

        // R5: slow reference mid-run, then restart
        tag = "R5";
        set_cfg(1, 0, 7, 1000); repeat (300) tick();
        ref_slow = 1'b1; tick();
        check("R5 zero while slow", offset, 0);
        repeat (10) tick();
        ref_slow = 1'b0; repeat (200) tick();

        // R6: random episodes
        tag = "R6";
        for (int ep = 0; ep < 40; ep++) begin
            int dn = $urandom_range(1, 0);
            int dv = $urandom_range(dn ? 18 : 26, 0);
            int pr = $urandom_range(1600, 210);
            int len = $urandom_range(1800, 200);
            set_cfg(($urandom_range(9, 0) != 0) ? 1 : 0, dn, dv, pr);
            for (int c = 0; c < len; c++) begin
                if ($urandom_range(499, 0) == 0) ref_slow = 1'b1;
                else if (ref_slow && $urandom_range(3, 0) == 0) ref_slow = 1'b0;
                tick();
            end
            ref_slow = 1'b0;
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule